// File: doc/BRIEF.md
# Sparsified Row Hit Buffer

This block keeps the hits of one row of 42 binary pixel comparators during a bunch train. On each bunch-crossing sample strobe (one strobe per 150 ns crossing) it latches all 42 hit bits at once. It then steps through the row as seven groups of six pixels, one group per fast clock cycle. Each group that holds at least one hit becomes a record made of the crossing timestamp, the group address and the six-bit hit pattern. The record goes into the next free slot of a pool of 19 write-once registers. Empty groups cost no storage.

When all slots are taken, further records are dropped and a sticky overflow flag is raised. A synchronous train clear empties the pool, drops the flag and restarts the timestamp. The readout side is a valid/ready stream that yields only the filled slots, in the order they were written. A test override makes every pixel read as hit, so the record path fills the memory with known patterns.

Top module: `row_hit_buf`

## Requirements
- R1: `smp_stb` high at a clock edge latches `pix_hit`. Groups 0 to 6 are then checked on the next seven edges: group g is judged at the (g+1)-th edge after the strobe edge, using the latched bits. Changes on `pix_hit` after the strobe edge have no effect on those records.
- R2: A group whose six latched bits are all zero produces no record.
- R3: A group with any bit set produces a record in the 30-bit output word. The fields are pattern in bits [5:0] (pixel g*6 in bit 0), group address 0..6 in bits [8:6] and timestamp in bits [21:9].
- R4: Records go into slots in strictly increasing order. Each slot is written at most once between clears, and at most 19 records are held.
- R5: A record that arrives when all 19 slots are full is dropped, and the stored records are unchanged.
- R6: A dropped record sets `ovf_flag`. The flag stays set until `train_clr` or reset, and it is copied into bit 28 of the output word.
- R7: `rd_valid` is high exactly while some written slot has not yet been read, and bit 29 of the word equals `rd_valid`. Records leave in write order. A record advances only on an edge with `rd_valid` and `rd_ready` both high. While `rd_valid` is high and `rd_ready` is low, bits [21:0] hold steady.
- R8: In override mode (`ovr_en` high at the strobe edge), all 42 latched bits read as one. This gives seven records with pattern 6'h3F.
- R9: The timestamp starts at 0 after reset or clear. A record carries the count of strobes seen before its own strobe. The count saturates at 8191 and does not wrap.
- R10: `train_clr` has priority over all else. It empties the pool, clears the overflow flag, zeroes the timestamp and aborts any group scan in progress. After reset the block is in the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast interrogation clock (8 cycles per crossing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_clr | input | 1 | Synchronous start-of-train clear |
| smp_stb | input | 1 | Bunch-crossing sample strobe, one cycle, at least 8 cycles apart |
| ovr_en | input | 1 | Test override: forces all pixels hit at the strobe |
| pix_hit | input | 42 | Comparator hit bits of the row |
| rd_ready | input | 1 | Readout sink ready |
| rd_valid | output | 1 | A stored record is presented |
| rd_data | output | 30 | Valid, overflow, padding, timestamp, group, pattern |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A record for group g is due on `rd_valid`/`rd_data` just after the (g+1)-th rising edge following the strobe edge. When the record is dropped, `ovf_flag` rises at that same edge instead. A handshake moves the read head on the edge where it occurs, and a clear empties the outputs on the very next edge. The bench keeps a behavioural model that it updates on each rising edge from the same sampled inputs. It compares the valid bit, the whole data word and the flag on every falling edge, so every result is checked in the cycle it is due. Inputs change only just after rising edges.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int unsigned NPIX  = 42;
  localparam int unsigned GRPW  = 6;
  localparam int unsigned TSW   = 13;
  localparam int unsigned WORDW = 30;
  localparam int unsigned NGRP  = NPIX / GRPW;
  localparam int unsigned GADW  = $clog2(NGRP);

  typedef struct packed {
    logic [TSW-1:0]  ts;
    logic [GADW-1:0] grp;
    logic [GRPW-1:0] pat;
  } rec_t;

  localparam int unsigned RECW = $bits(rec_t);
  localparam int unsigned PADW = WORDW - RECW - 2;
endpackage

// File: rtl/rhb_capture.sv
module rhb_capture
  import rhb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            stb,
  input  logic            ovr,
  input  logic [NPIX-1:0] pix,
  output logic            cand_vld,
  output rec_t            cand_rec
);
  logic [NPIX-1:0] lat_q;
  logic [TSW-1:0]  ts_cnt_q, ts_lat_q;
  logic            scan_q;
  logic [GADW-1:0] gidx_q;
  logic [GRPW-1:0] grp_pat [NGRP];
  logic [GRPW-1:0] cur_pat;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    assign grp_pat[g] = lat_q[g*GRPW +: GRPW];
  end

  always_comb begin
    cur_pat = '0;
    for (int i = 0; i < NGRP; i++)
      if (gidx_q == GADW'(i)) cur_pat = grp_pat[i];
  end

  assign cand_vld = scan_q && (cur_pat != '0);
  assign cand_rec = '{ts: ts_lat_q, grp: gidx_q, pat: cur_pat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '0;
      ts_cnt_q <= '0;
      ts_lat_q <= '0;
      scan_q   <= 1'b0;
      gidx_q   <= '0;
    end else if (clr) begin
      ts_cnt_q <= '0;
      scan_q   <= 1'b0;
      gidx_q   <= '0;
    end else if (stb) begin
      lat_q    <= ovr ? '1 : pix;
      ts_lat_q <= ts_cnt_q;
      if (ts_cnt_q != '1) ts_cnt_q <= ts_cnt_q + 1'b1;
      scan_q   <= 1'b1;
      gidx_q   <= '0;
    end else if (scan_q) begin
      if (gidx_q == GADW'(NGRP-1)) begin
        scan_q <= 1'b0;
        gidx_q <= '0;
      end else begin
        gidx_q <= gidx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rhb_slot_mem.sv
module rhb_slot_mem
  import rhb_pkg::*;
#(
  parameter int unsigned NSLOT = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_vld,
  input  rec_t wr_rec,
  input  logic rd_ready,
  output logic rd_valid,
  output rec_t rd_rec,
  output logic ovf
);
  localparam int unsigned CNTW = $clog2(NSLOT + 1);

  rec_t            slot_q [NSLOT];
  logic [NSLOT-1:0] used_q;
  logic [CNTW-1:0] wcnt_q, rptr_q;
  logic            pool_full, head_used;

  assign pool_full = (wcnt_q == CNTW'(NSLOT));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic take;
    assign take = wr_vld && !pool_full && !used_q[s] && (wcnt_q == CNTW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[s] <= 1'b0;
        slot_q[s] <= '0;
      end else if (clr) begin
        used_q[s] <= 1'b0;
      end else if (take) begin
        used_q[s] <= 1'b1;
        slot_q[s] <= wr_rec;
      end
    end
  end

  always_comb begin
    rd_rec    = '0;
    head_used = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (rptr_q == CNTW'(i)) begin
        rd_rec    = slot_q[i];
        head_used = used_q[i];
      end
  end

  assign rd_valid = (rptr_q != wcnt_q) && head_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      rptr_q <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      wcnt_q <= '0;
      rptr_q <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_vld && !pool_full) wcnt_q <= wcnt_q + 1'b1;
      if (wr_vld && pool_full)  ovf    <= 1'b1;
      if (rd_valid && rd_ready) rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/row_hit_buf.sv
module row_hit_buf
  import rhb_pkg::*;
#(
  parameter int unsigned NSLOT = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_clr,
  input  logic             smp_stb,
  input  logic             ovr_en,
  input  logic [NPIX-1:0]  pix_hit,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WORDW-1:0] rd_data,
  output logic             ovf_flag
);
  logic cand_vld;
  rec_t cand_rec, head_rec;

  rhb_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (train_clr),
    .stb      (smp_stb),
    .ovr      (ovr_en),
    .pix      (pix_hit),
    .cand_vld (cand_vld),
    .cand_rec (cand_rec)
  );

  rhb_slot_mem #(.NSLOT(NSLOT)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (train_clr),
    .wr_vld   (cand_vld),
    .wr_rec   (cand_rec),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_rec   (head_rec),
    .ovf      (ovf_flag)
  );

  assign rd_data = {rd_valid, ovf_flag, {PADW{1'b0}},
                    (rd_valid ? head_rec : rec_t'('0))};
endmodule

// File: rtl/row_hit_buf_chk.sv
module row_hit_buf_chk
  import rhb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             train_clr,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic [WORDW-1:0] rd_data,
  input logic             ovf_flag
);
  // R6: flag is sticky until a clear
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !train_clr |=> ovf_flag);
  // R6: word carries the flag
  a_r6_ovf_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[28] == ovf_flag);
  // R7: valid bit mirrors the stream valid
  a_r7_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29] == rd_valid);
  // R7: stalled record held steady
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !train_clr |=> rd_valid && $stable(rd_data[21:0]));
  // R3: group address range
  a_r3_grp_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[8:6] < 3'(NGRP));
  // R2: no empty pattern stored
  a_r2_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[5:0] != 6'd0);
  // R10: clear empties the outputs
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    train_clr |=> !rd_valid && !ovf_flag);
endmodule

bind row_hit_buf row_hit_buf_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .train_clr (train_clr),
  .rd_ready  (rd_ready),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_row_hit_buf.sv
`timescale 1ns/1ps
module sim_row_hit_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_clr = 1'b0, smp_stb = 1'b0, ovr_en = 1'b0, rd_ready = 1'b0;
  logic [41:0] pix_hit = '0;
  logic        rd_valid, ovf_flag;
  logic [29:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  always #4 clk = ~clk;

  row_hit_buf u0 (.clk(clk), .rst_n(rst_n), .train_clr(train_clr),
    .smp_stb(smp_stb), .ovr_en(ovr_en), .pix_hit(pix_hit), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flag(ovf_flag));

  // behavioural reference
  logic [21:0] m_mem[$];
  logic [41:0] m_lat;
  int m_ts, m_tsl, m_gi, m_rdp;
  bit m_ovf;

  always @(posedge clk) begin
    if (!rst_n || train_clr) begin            // R10
      m_mem.delete(); m_ts = 0; m_gi = -1; m_rdp = 0; m_ovf = 0;
      if (!rst_n) begin m_lat = '0; m_tsl = 0; end
    end else begin
      if (m_rdp < m_mem.size() && rd_ready) m_rdp++;  // R7
      if (m_gi >= 0) begin
        logic [5:0] p;
        p = m_lat[m_gi*6 +: 6];
        if (p != 0) begin                      // R2 R3
          if (m_mem.size() < 19) m_mem.push_back({13'(m_tsl), 3'(m_gi), p}); // R4
          else m_ovf = 1;                      // R5 R6
        end
        m_gi++;
        if (m_gi == 7) m_gi = -1;
      end
      if (smp_stb) begin                       // R1 R8 R9
        m_lat = ovr_en ? '1 : pix_hit;
        m_tsl = m_ts;
        if (m_ts < 8191) m_ts++;
        m_gi = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic ev;
    logic [29:0] ew;
    ev = (m_rdp < m_mem.size());
    ew = {ev, m_ovf, 6'd0, ev ? m_mem[m_rdp] : 22'd0};
    chk("R7 rd_valid", 32'(rd_valid), 32'(ev));
    chk("R3 rd_data", 32'(rd_data), 32'(ew));
    chk("R6 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(logic [41:0] p, logic o, logic [41:0] after);
    smp_stb = 1; pix_hit = p; ovr_en = o;
    cyc(1);
    smp_stb = 0; pix_hit = after; ovr_en = 0;
    cyc(7);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      rd_ready = (i % 3 != 0);
      cyc(1);
    end
    rd_ready = 0;
  endtask

  task automatic clear();
    train_clr = 1; cyc(1); train_clr = 0;
  endtask

  initial begin
    int cnt;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset valid", 32'(rd_valid), 0);
    chk("R10 reset ovf", 32'(ovf_flag), 0);
    #1;
    clear();
    // R1 R3: groups 0,3,6 hit, input changes during scan
    strobe(42'h0000000000 | 42'h1 | (42'h2A << 18) | (42'h20 << 36), 0, '1);
    // R2: empty row
    strobe('0, 0, '1);
    strobe(42'h3FFFFFFFFFF & (42'h3F << 12), 0, '0);
    drain(20);
    // R8 R4 R5 R6: override fills past capacity
    strobe('0, 1, '0);
    strobe('0, 1, '0);
    strobe('0, 1, '0);
    strobe(42'h1, 0, '0);
    drain(40);
    strobe(42'h1, 0, '0);   // R5: still full after reads
    drain(5);
    @(negedge clk);
    chk("R6 ovf held", 32'(ovf_flag), 1);
    #1;
    clear();                // R10
    @(negedge clk);
    chk("R10 clear ovf", 32'(ovf_flag), 0);
    #1;
    // R9: timestamp saturation
    for (int i = 0; i < 8195; i++) begin
      smp_stb = 1; cyc(1); smp_stb = 0; cyc(7);
    end
    strobe(42'h1 << 41, 0, '0);
    @(negedge clk);
    chk("R9 saturated ts", 32'(rd_data[21:9]), 32'd8191);
    #1;
    rd_ready = 1; cyc(3); rd_ready = 0;
    cyc(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule